// File: doc/BRIEF.md
# Priority Throttle Event Arbiter

This block picks one throttle event out of several concurrent requests and hands that event's clock throttle settings to downstream pulse-skipping logic. Typical requesters are a light thermal event, a heavy thermal event and an overcurrent event. Each event owns three configuration values:

- a priority,
- a CPU skip depth given as a percentage,
- a GPU skip level given as a two-bit code.

Software loads these values through a narrow write port. A write names the event, the field and the data.

On every clock the block looks at the request lines that are raised, keeps the event whose priority is strictly greatest, and registers that event's index and settings. Ties go to the lowest event index. A priority of zero takes an event out of the contest. When nothing qualifies, the outputs fall back to no throttling.

Top module: `thr_arbiter`

## Requirements
- R1: A priority write stores values 0 to 100 unchanged; any larger write value is saturated to 100.
- R2: Among requesting, enabled events, the one with the numerically larger priority wins.
- R3: While `thr_valid` is high, `thr_evt`, `thr_cpu_pct` and `thr_gpu_lvl` are the index and stored settings of the winning event, and that event was requesting.
- R4: A CPU depth write stores 0 to 100 unchanged; any larger value is saturated to 100. `thr_cpu_pct` never exceeds 100.
- R5: The GPU level takes bits [1:0] of the write data, and the upper bits are dropped. The codes are 0 none, 1 low, 2 medium and 3 high.
- R6: When enabled, requesting events share the top priority, the lowest event index wins.
- R7: With no qualifying request, the outputs are `thr_valid`=0, `thr_evt`=0, `thr_cpu_pct`=0 and `thr_gpu_lvl`=0.
- R8: An event whose stored priority is 0 never wins, even if it is the only event requesting.
- R9: The outputs change exactly one clock edge after a request or configuration change is visible at the inputs, and they do not change before that edge.
- R10: Reset clears every stored priority, depth and level to 0 and drives the outputs to the idle values.
- R11: Field codes are 0 priority, 1 CPU depth, 2 GPU level and 3 reserved. A write with `cfg_we` low, a write to an event index at or above the number of events, or a write with field code 3 changes no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_req | input | NUM_EVT | Request line for each event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_evt | input | EVT_W | Index of the event being written |
| cfg_field | input | 2 | Field code (0 priority, 1 CPU depth, 2 GPU level, 3 reserved) |
| cfg_wdata | input | DATA_W | Write data |
| thr_valid | output | 1 | An event is selected |
| thr_evt | output | EVT_W | Index of the selected event |
| thr_cpu_pct | output | PCT_W | CPU skip depth in percent |
| thr_gpu_lvl | output | 2 | GPU skip level code |

## Verification
The bench builds the block with its defaults: three events, 8-bit write data and 7-bit priority and depth fields. With three events the 2-bit event index has one spare code, 3, and the bench aims a write at that code to show that the write lands nowhere. The write data is one bit wider than the stored fields, so the values 200 and 250 can be written. Saturation then gives 100, while plain truncation would give 72 and 122, so the bench can tell the two apart. A priority of 99 against a saturated 100 is set up so that the winner depends on which of those two behaviours the design has.

// File: rtl/thr_pkg.sv
package thr_pkg;

   // Field codes accepted on the configuration port
   typedef enum logic [1:0] {
      FLD_PRIO = 2'd0,
      FLD_CPU  = 2'd1,
      FLD_GPU  = 2'd2,
      FLD_RSVD = 2'd3
   } cfg_field_e;

   // GPU skip level codes
   typedef enum logic [1:0] {
      GLVL_NONE = 2'd0,
      GLVL_LOW  = 2'd1,
      GLVL_MED  = 2'd2,
      GLVL_HIGH = 2'd3
   } gpu_lvl_e;

   localparam int LVL_W = 2;

endpackage

// File: rtl/thr_cfg_bank.sv
module thr_cfg_bank
   import thr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PRIO_W   = 7,
   parameter int PRIO_MAX = 100,
   parameter int PCT_W    = 7,
   parameter int PCT_MAX  = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_field,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PRIO_W-1:0] prio_q,
   output logic [PCT_W-1:0]  pct_q,
   output logic [LVL_W-1:0]  lvl_q
);

   logic [PRIO_W-1:0] prio_sat;
   logic [PCT_W-1:0]  pct_sat;

   always_comb begin
      if (int'(wr_data) > PRIO_MAX) prio_sat = PRIO_W'(PRIO_MAX);
      else                          prio_sat = wr_data[PRIO_W-1:0];
      if (int'(wr_data) > PCT_MAX)  pct_sat  = PCT_W'(PCT_MAX);
      else                          pct_sat  = wr_data[PCT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         pct_q  <= '0;
         lvl_q  <= '0;
      end else if (wr_en) begin
         case (cfg_field_e'(wr_field))
            FLD_PRIO: prio_q <= prio_sat;
            FLD_CPU:  pct_q  <= pct_sat;
            FLD_GPU:  lvl_q  <= wr_data[LVL_W-1:0];
            default:  ;
         endcase
      end
   end

   assert_prio_sat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(prio_q) <= PRIO_MAX);

   assert_pct_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pct_q) <= PCT_MAX);

   assert_no_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_field == 2'd3) |=> ($stable(prio_q) && $stable(pct_q) && $stable(lvl_q)));

endmodule

// File: rtl/thr_select.sv
module thr_select
   import thr_pkg::*;
#(
   parameter int NUM_EVT = 3,
   parameter int EVT_W   = 2,
   parameter int PRIO_W  = 7,
   parameter int PCT_W   = 7
) (
   input  logic [NUM_EVT-1:0] req,
   input  logic [PRIO_W-1:0]  prio [NUM_EVT],
   input  logic [PCT_W-1:0]   pct  [NUM_EVT],
   input  logic [LVL_W-1:0]   lvl  [NUM_EVT],
   output logic               sel_hit,
   output logic [EVT_W-1:0]   sel_idx,
   output logic [PCT_W-1:0]   sel_pct,
   output logic [LVL_W-1:0]   sel_lvl
);

   logic [PRIO_W-1:0] best;

   // Ascending scan with a strict compare: a later event must beat the
   // current best outright, so on a tie the lower index is kept. The best
   // value starts at zero, so a zero priority can never win.
   always_comb begin
      best    = '0;
      sel_hit = 1'b0;
      sel_idx = '0;
      sel_pct = '0;
      sel_lvl = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (req[i] && (prio[i] > best)) begin
            best    = prio[i];
            sel_hit = 1'b1;
            sel_idx = EVT_W'(i);
            sel_pct = pct[i];
            sel_lvl = lvl[i];
         end
      end
   end

endmodule

// File: rtl/thr_out_reg.sv
module thr_out_reg
   import thr_pkg::*;
#(
   parameter int EVT_W   = 2,
   parameter int PCT_W   = 7,
   parameter int PCT_MAX = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_hit,
   input  logic [EVT_W-1:0] d_idx,
   input  logic [PCT_W-1:0] d_pct,
   input  logic [LVL_W-1:0] d_lvl,
   output logic             q_valid,
   output logic [EVT_W-1:0] q_idx,
   output logic [PCT_W-1:0] q_pct,
   output logic [LVL_W-1:0] q_lvl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_idx   <= '0;
         q_pct   <= '0;
         q_lvl   <= '0;
      end else begin
         q_valid <= d_hit;
         q_idx   <= d_hit ? d_idx : '0;
         q_pct   <= d_hit ? d_pct : '0;
         q_lvl   <= d_hit ? d_lvl : '0;
      end
   end

   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> (q_idx == '0 && q_pct == '0 && q_lvl == '0));

   assert_out_pct_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_pct) <= PCT_MAX);

   assert_one_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (q_valid == $past(d_hit)));

endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter
   import thr_pkg::*;
#(
   parameter int NUM_EVT  = 3,
   parameter int DATA_W   = 8,
   parameter int PRIO_W   = 7,
   parameter int PRIO_MAX = 100,
   parameter int PCT_W    = 7,
   parameter int PCT_MAX  = 100,
   localparam int EVT_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_req,
   input  logic               cfg_we,
   input  logic [EVT_W-1:0]   cfg_evt,
   input  logic [1:0]         cfg_field,
   input  logic [DATA_W-1:0]  cfg_wdata,
   output logic               thr_valid,
   output logic [EVT_W-1:0]   thr_evt,
   output logic [PCT_W-1:0]   thr_cpu_pct,
   output logic [1:0]         thr_gpu_lvl
);

   // Elaboration-time parameter checks
   if (NUM_EVT < 1) begin : g_bad_num
      $error("thr_arbiter: NUM_EVT must be at least 1");
   end
   if (DATA_W < PRIO_W || DATA_W < PCT_W || DATA_W < LVL_W) begin : g_bad_data
      $error("thr_arbiter: DATA_W narrower than a stored field");
   end
   if (PRIO_MAX >= (1 << PRIO_W) || PRIO_MAX < 1) begin : g_bad_prio
      $error("thr_arbiter: PRIO_MAX does not fit PRIO_W");
   end
   if (PCT_MAX >= (1 << PCT_W)) begin : g_bad_pct
      $error("thr_arbiter: PCT_MAX does not fit PCT_W");
   end

   logic [PRIO_W-1:0] prio_a [NUM_EVT];
   logic [PCT_W-1:0]  pct_a  [NUM_EVT];
   logic [LVL_W-1:0]  lvl_a  [NUM_EVT];
   logic [NUM_EVT-1:0] wr_hit;

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
      assign wr_hit[g] = cfg_we && (cfg_evt == EVT_W'(g));

      thr_cfg_bank #(
         .DATA_W   (DATA_W),
         .PRIO_W   (PRIO_W),
         .PRIO_MAX (PRIO_MAX),
         .PCT_W    (PCT_W),
         .PCT_MAX  (PCT_MAX)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_hit[g]),
         .wr_field (cfg_field),
         .wr_data  (cfg_wdata),
         .prio_q   (prio_a[g]),
         .pct_q    (pct_a[g]),
         .lvl_q    (lvl_a[g])
      );
   end

   logic             s_hit;
   logic [EVT_W-1:0] s_idx;
   logic [PCT_W-1:0] s_pct;
   logic [LVL_W-1:0] s_lvl;

   thr_select #(
      .NUM_EVT (NUM_EVT),
      .EVT_W   (EVT_W),
      .PRIO_W  (PRIO_W),
      .PCT_W   (PCT_W)
   ) u_select (
      .req     (evt_req),
      .prio    (prio_a),
      .pct     (pct_a),
      .lvl     (lvl_a),
      .sel_hit (s_hit),
      .sel_idx (s_idx),
      .sel_pct (s_pct),
      .sel_lvl (s_lvl)
   );

   thr_out_reg #(
      .EVT_W   (EVT_W),
      .PCT_W   (PCT_W),
      .PCT_MAX (PCT_MAX)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_hit   (s_hit),
      .d_idx   (s_idx),
      .d_pct   (s_pct),
      .d_lvl   (s_lvl),
      .q_valid (thr_valid),
      .q_idx   (thr_evt),
      .q_pct   (thr_cpu_pct),
      .q_lvl   (thr_gpu_lvl)
   );

   // Registered copy of the requests, kept only for the checks below
   logic [NUM_EVT-1:0] req_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= evt_req;
   end

   assert_no_req_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_req == '0) |=> (!thr_valid && thr_cpu_pct == '0 && thr_gpu_lvl == '0));

   assert_winner_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
      thr_valid |-> ((req_q >> thr_evt) & NUM_EVT'(1)) != '0);

   assert_evt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr_evt) < NUM_EVT);

endmodule

// File: tb/thr_arbiter_test.sv
module thr_arbiter_test;
   import thr_pkg::*;

   localparam int NUM_EVT = 3;
   localparam int EVT_W   = 2;
   localparam int DATA_W  = 8;
   localparam int PCT_W   = 7;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_EVT-1:0] evt_req = '0;
   logic               cfg_we = 1'b0;
   logic [EVT_W-1:0]   cfg_evt = '0;
   logic [1:0]         cfg_field = '0;
   logic [DATA_W-1:0]  cfg_wdata = '0;
   logic               thr_valid;
   logic [EVT_W-1:0]   thr_evt;
   logic [PCT_W-1:0]   thr_cpu_pct;
   logic [1:0]         thr_gpu_lvl;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   thr_arbiter #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_req     (evt_req),
      .cfg_we      (cfg_we),
      .cfg_evt     (cfg_evt),
      .cfg_field   (cfg_field),
      .cfg_wdata   (cfg_wdata),
      .thr_valid   (thr_valid),
      .thr_evt     (thr_evt),
      .thr_cpu_pct (thr_cpu_pct),
      .thr_gpu_lvl (thr_gpu_lvl)
   );

   task automatic chk(string tag, bit v, int e, int p, int l);
      n_checks++;
      if (thr_valid !== v || int'(thr_evt) != e || int'(thr_cpu_pct) != p || int'(thr_gpu_lvl) != l) begin
         n_errors++;
         $display("FAIL %s: got valid=%0b evt=%0d pct=%0d lvl=%0d, expected valid=%0b evt=%0d pct=%0d lvl=%0d",
                  tag, thr_valid, thr_evt, thr_cpu_pct, thr_gpu_lvl, v, e, p, l);
      end
   endtask

   // Drive one write at a falling edge; it lands on the next rising edge.
   task automatic wr(int evt, int fld, int data, bit we = 1'b1);
      cfg_we    = we;
      cfg_evt   = EVT_W'(evt);
      cfg_field = 2'(fld);
      cfg_wdata = DATA_W'(data);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // Apply requests and sample after one rising edge.
   task automatic req_and_wait(logic [NUM_EVT-1:0] r);
      evt_req = r;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R10 reset outputs", 0, 0, 0, 0);
      req_and_wait(3'b111);
      chk("R10 R8 unprogrammed priorities stay disabled", 0, 0, 0, 0);
      req_and_wait(3'b000);
   endtask

   task automatic t_program_and_pick();
      wr(0, FLD_PRIO, 50);  wr(0, FLD_CPU, 75); wr(0, FLD_GPU, GLVL_MED);
      wr(1, FLD_PRIO, 100); wr(1, FLD_CPU, 85); wr(1, FLD_GPU, GLVL_HIGH);
      wr(2, FLD_PRIO, 80);  wr(2, FLD_CPU, 50); wr(2, FLD_GPU, GLVL_LOW);
      req_and_wait(3'b001); chk("R3 R5 single event 0", 1, 0, 75, 2);
      req_and_wait(3'b010); chk("R3 R5 single event 1", 1, 1, 85, 3);
      req_and_wait(3'b100); chk("R3 R5 single event 2", 1, 2, 50, 1);
      req_and_wait(3'b111); chk("R2 all three active", 1, 1, 85, 3);
      req_and_wait(3'b101); chk("R2 events 0 and 2", 1, 2, 50, 1);
      req_and_wait(3'b011); chk("R2 events 0 and 1", 1, 1, 85, 3);
   endtask

   task automatic t_latency();
      req_and_wait(3'b000);
      chk("R7 idle after release", 0, 0, 0, 0);
      evt_req = 3'b100;
      #1;
      chk("R9 no change before edge", 0, 0, 0, 0);
      @(negedge clk);
      chk("R9 change after one edge", 1, 2, 50, 1);
   endtask

   task automatic t_tie();
      wr(2, FLD_PRIO, 100);
      req_and_wait(3'b110); chk("R6 tie events 1 and 2", 1, 1, 85, 3);
      wr(0, FLD_PRIO, 100);
      req_and_wait(3'b111); chk("R6 three-way tie", 1, 0, 75, 2);
      wr(0, FLD_PRIO, 50);
      wr(2, FLD_PRIO, 80);
   endtask

   task automatic t_saturate();
      wr(1, FLD_PRIO, 99);
      wr(2, FLD_PRIO, 200);
      wr(2, FLD_CPU, 250);
      wr(2, FLD_GPU, 8'hFE);
      req_and_wait(3'b110); chk("R1 R4 R5 saturated priority and depth", 1, 2, 100, 2);
   endtask

   task automatic t_disable();
      wr(2, FLD_PRIO, 0);
      req_and_wait(3'b100); chk("R8 only zero-priority event", 0, 0, 0, 0);
      req_and_wait(3'b110); chk("R8 zero priority loses to 99", 1, 1, 85, 3);
   endtask

   task automatic t_ignored();
      wr(1, FLD_PRIO, 60);
      wr(0, FLD_PRIO, 100, 1'b0);   // strobe low
      wr(3, FLD_PRIO, 127);         // index beyond the events
      wr(3, FLD_CPU, 9);
      wr(0, 3, 8'hFF);              // reserved field
      req_and_wait(3'b011); chk("R11 event 0 priority untouched", 1, 1, 85, 3);
      req_and_wait(3'b001); chk("R11 event 0 settings untouched", 1, 0, 75, 2);
      req_and_wait(3'b000); chk("R7 no request", 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program_and_pick();
      t_latency();
      t_tie();
      t_saturate();
      t_disable();
      t_ignored();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule